// File: doc/BRIEF.md
# UART Control Register Block

This block is the processor-facing side of a serial port. A byte-wide register bus with a 6-bit offset reaches a pair of mode bytes, a status byte, an interrupt status and mask pair, two fixed baud divisor bytes and the transmit holding byte. A packed command byte resets, enables or disables the transmit and receive channels. It can also rewind the mode pointer and clear the break-change flag.

Transmit bytes leave through a valid/ready handshake toward a serializer. Received bytes come from a separate receive FIFO, which supplies its head byte, its ready and full flags and its error flags. The FIFO takes a pop strobe, a flush pulse and an enable level from this block. One level-sensitive interrupt line is raised while any unmasked interrupt source is active.

Bus accesses complete in one cycle. Read data and the pop strobe are combinational in the access cycle. Writes take effect at the clock edge that ends the access.

Top module: `uart_ctrl_regs`

## Requirements
- R1: After reset, status reads 0x08, interrupt status reads 0x00 and the mode byte reads 0x00. The interrupt line, tx_valid and rx_en are low.
- R2: Offset 0x00 holds two mode bytes behind a pointer that starts on the first byte. Every write there stores to the selected byte and moves the pointer to the second byte. Misc command code 1 (command bits 6:4) moves the pointer back to the first byte. A read returns the selected byte and leaves the pointer unchanged.
- R3: The status byte is read at 0x04. Bit 0 is FIFO ready and bit 1 is FIFO full. Bit 2 is transmitter enabled and bit 3 is holding byte empty. Bits 7:4 are rx_err[3:0] (overrun, parity, framing, break). Writes to 0x04 change nothing.
- R4: Command bits 3:2 control the transmitter: 1 enables it, 2 disables it and 3 is ignored. Misc code 3 disables the transmitter, marks it empty and discards any pending byte. The field is applied after the misc code.
- R5: Command bits 1:0 control the receiver in the same way: 1 enables, 2 disables, 3 is ignored. Misc code 2 disables the receiver and pulses rx_flush for exactly the cycle of the command write. The field is applied after the misc code.
- R6: A write to 0x0C latches the byte and clears empty. tx_valid is high while the transmitter is enabled and not empty, and tx_data holds the byte steady until accepted. A cycle with tx_valid and tx_ready sets empty again. A new write in that same cycle wins, leaving the new byte pending.
- R7: A read of 0x0C returns rx_data and pulses rx_pop in that cycle when FIFO ready is high. Otherwise it returns 0x00 with no pop. No other read pops.
- R8: Interrupt status is read at 0x14. Bit 0 is transmitter enabled. Bit 1 is FIFO full when bit 6 of the first mode byte is set, and FIFO ready when it is clear. Bit 2 is the break-change flag and bit 7 is cos_flag. A write to 0x14 loads the mask.
- R9: irq is high exactly when interrupt status AND mask is nonzero.
- R10: brk_evt sets the break-change flag. Misc code 5 clears it and pulses dbrk_clr. When both fall in the same cycle, the flag stays set.
- R11: Offsets 0x18 and 0x1C read the DIV_A and DIV_B parameters. Offsets 0x08, 0x10 and every unlisted offset read 0x00. Writes to 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tx_valid | output | 1 | Transmit byte offered to serializer |
| tx_ready | input | 1 | Serializer accepts byte |
| tx_data | output | 8 | Transmit byte |
| rx_ready | input | 1 | Receive FIFO holds data |
| rx_full | input | 1 | Receive FIFO full |
| rx_err | input | 4 | Receive error flags for status bits 7:4 |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_en | output | 1 | Receiver enabled |
| rx_flush | output | 1 | Receive FIFO flush pulse |
| brk_evt | input | 1 | Break change detected |
| cos_flag | input | 1 | Change-of-state source |
| dbrk_clr | output | 1 | Break-change clear pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives two kinds of collision in a single bus cycle.

In the first, the serializer accepts the pending byte in the same cycle that a new byte is written to the transmit offset. The check is that tx_valid stays high with the new byte and that status bit 3 stays clear.

In the second, a break event arrives in the same cycle as the command that clears the break-change flag. The check is that the dbrk_clr pulse is seen while a later read of interrupt status still shows bit 2 set.

Command bytes that combine a misc reset with an enable are also written, to confirm that the enable field is applied after the reset.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_AUX  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_INT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_DIVA = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DIVB = 6'h1C;

    localparam int RXSRC_BIT = 6;   // mode byte 0 bit picking the rx interrupt source

    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_code_e;

    typedef enum logic [1:0] {
        CH_KEEP = 2'd0,
        CH_ON   = 2'd1,
        CH_OFF  = 2'd2,
        CH_RSVD = 2'd3
    } chan_code_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
`timescale 1ns/1ps
module uart_cmd_decode
    import uart_regs_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd,
    output cmd_act_t          act
);
    localparam int NCH = 2;   // channel fields: index 0 receiver, 1 transmitter

    misc_code_e     misc;
    logic [NCH-1:0] ch_on;
    logic [NCH-1:0] ch_off;

    assign misc = misc_code_e'(cmd[6:4]);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        chan_code_e code;
        assign code      = chan_code_e'(cmd[2*g+1:2*g]);
        assign ch_on[g]  = cmd_valid && (code == CH_ON);
        assign ch_off[g] = cmd_valid && (code == CH_OFF);
    end

    always_comb begin
        act         = '0;
        act.ptr_rst = cmd_valid && (misc == MISC_PTR_RST);
        act.rx_rst  = cmd_valid && (misc == MISC_RX_RST);
        act.tx_rst  = cmd_valid && (misc == MISC_TX_RST);
        act.brk_clr = cmd_valid && (misc == MISC_BRK_CLR);
        act.rx_on   = ch_on[0];
        act.rx_off  = ch_off[0];
        act.tx_on   = ch_on[1];
        act.tx_off  = ch_off[1];
    end

endmodule

// File: rtl/uart_tx_hold.sv
`timescale 1ns/1ps
module uart_tx_hold
    import uart_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              enable,
    input  logic              drop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              empty
);
    typedef struct packed {
        logic              empty;
        logic [DATA_W-1:0] data;
    } hold_t;

    localparam hold_t HOLD_RST = '{empty: 1'b1, data: '0};

    hold_t hold_d, hold_q;

    assign tx_valid = enable && !hold_q.empty;
    assign tx_data  = hold_q.data;
    assign empty    = hold_q.empty;

    always_comb begin
        hold_d = hold_q;
        if (drop) begin
            hold_d.empty = 1'b1;
        end else if (load) begin
            hold_d.empty = 1'b0;
            hold_d.data  = load_data;
        end else if (tx_valid && tx_ready) begin
            hold_d.empty = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= HOLD_RST;
        else        hold_q <= hold_d;
    end

endmodule

// File: rtl/uart_irq_gen.sv
`timescale 1ns/1ps
module uart_irq_gen
    import uart_regs_pkg::*;
(
    input  logic              tx_rdy,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic              full_sel,
    input  logic              dbrk,
    input  logic              cos,
    input  logic [DATA_W-1:0] imr,
    output logic [DATA_W-1:0] isr,
    output logic              irq
);
    logic rx_src;

    assign rx_src = full_sel ? rx_full : rx_ready;
    assign isr    = {cos, 4'b0000, dbrk, rx_src, tx_rdy};
    assign irq    = |(isr & imr);

endmodule

// File: rtl/uart_ctrl_regs.sv
`timescale 1ns/1ps
module uart_ctrl_regs
    import uart_regs_pkg::*;
#(
    parameter logic [7:0] DIV_A = 8'h00,
    parameter logic [7:0] DIV_B = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_ready,
    input  logic              rx_full,
    input  logic [3:0]        rx_err,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_pop,
    output logic              rx_en,
    output logic              rx_flush,
    input  logic              brk_evt,
    input  logic              cos_flag,
    output logic              dbrk_clr,
    output logic              irq
);
    localparam int NMODE = 2;

    typedef struct packed {
        logic [NMODE-1:0][DATA_W-1:0] mode;
        logic                         ptr;
        logic [DATA_W-1:0]            imr;
        logic                         tx_en;
        logic                         rx_en;
        logic                         dbrk;
    } ctl_t;

    localparam ctl_t CTL_RST = '0;

    ctl_t              ctl_d, ctl_q;
    cmd_act_t          act;
    logic              wr_acc, rd_acc;
    logic              tx_empty;
    logic [DATA_W-1:0] isr;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] imr_q;
    logic              dbrk_q;

    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;
    assign imr_q  = ctl_q.imr;
    assign dbrk_q = ctl_q.dbrk;

    uart_cmd_decode u_dec (
        .cmd_valid (wr_acc && (bus_addr == OFS_CMD)),
        .cmd       (bus_wdata),
        .act       (act)
    );

    uart_tx_hold u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_acc && (bus_addr == OFS_DATA)),
        .load_data (bus_wdata),
        .enable    (ctl_q.tx_en),
        .drop      (act.tx_rst),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .empty     (tx_empty)
    );

    uart_irq_gen u_irq (
        .tx_rdy   (ctl_q.tx_en),
        .rx_ready (rx_ready),
        .rx_full  (rx_full),
        .full_sel (ctl_q.mode[0][RXSRC_BIT]),
        .dbrk     (dbrk_q),
        .cos      (cos_flag),
        .imr      (imr_q),
        .isr      (isr),
        .irq      (irq)
    );

    // next-state: misc action first, then transmitter, then receiver field
    always_comb begin
        ctl_d = ctl_q;
        if (wr_acc && (bus_addr == OFS_MODE)) begin
            ctl_d.mode[ctl_q.ptr] = bus_wdata;
            ctl_d.ptr             = 1'b1;
        end
        if (act.ptr_rst) ctl_d.ptr = 1'b0;
        if (act.tx_rst)  ctl_d.tx_en = 1'b0;
        if (act.tx_on)   ctl_d.tx_en = 1'b1;
        if (act.tx_off)  ctl_d.tx_en = 1'b0;
        if (act.rx_rst)  ctl_d.rx_en = 1'b0;
        if (act.rx_on)   ctl_d.rx_en = 1'b1;
        if (act.rx_off)  ctl_d.rx_en = 1'b0;
        if (act.brk_clr) ctl_d.dbrk = 1'b0;
        if (brk_evt)     ctl_d.dbrk = 1'b1;   // a new event outranks the clear
        if (wr_acc && (bus_addr == OFS_INT)) ctl_d.imr = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign status   = {rx_err, tx_empty, ctl_q.tx_en, rx_full, rx_ready};
    assign rx_pop   = rd_acc && (bus_addr == OFS_DATA) && rx_ready;
    assign rx_en    = ctl_q.rx_en;
    assign rx_flush = act.rx_rst;
    assign dbrk_clr = act.brk_clr;

    always_comb begin
        unique case (bus_addr)
            OFS_MODE: bus_rdata = ctl_q.mode[ctl_q.ptr];
            OFS_STAT: bus_rdata = status;
            OFS_DATA: bus_rdata = rx_ready ? rx_data : '0;
            OFS_INT:  bus_rdata = isr;
            OFS_DIVA: bus_rdata = DIV_A;
            OFS_DIVB: bus_rdata = DIV_B;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_ctrl_regs_chk.sv
`timescale 1ns/1ps
module uart_ctrl_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [5:0] bus_addr,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       rx_ready,
    input logic       rx_pop,
    input logic       rx_en,
    input logic       rx_flush,
    input logic       brk_evt,
    input logic       irq,
    input logic [7:0] imr_q,
    input logic       dbrk_q
);
    logic wr_any;
    assign wr_any = bus_sel && bus_wr;

    assert_pop_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (bus_sel && !bus_wr && rx_ready && bus_addr == 6'h0C));

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_any) |=> (tx_valid && $stable(tx_data)));

    assert_tx_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !wr_any) |=> !tx_valid);

    assert_flush_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> (wr_any && bus_addr == 6'h08));

    assert_rxen_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> $past(wr_any && bus_addr == 6'h08));

    assert_irq_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (imr_q == 8'h00) |-> !irq);

    assert_brk_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> dbrk_q);

endmodule

bind uart_ctrl_regs uart_ctrl_regs_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .rx_ready (rx_ready),
    .rx_pop   (rx_pop),
    .rx_en    (rx_en),
    .rx_flush (rx_flush),
    .brk_evt  (brk_evt),
    .irq      (irq),
    .imr_q    (imr_q),
    .dbrk_q   (dbrk_q)
);

// File: tb/uart_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module uart_ctrl_regs_tb_top;
    localparam logic [7:0] DIV_A = 8'h2A;
    localparam logic [7:0] DIV_B = 8'h01;
    localparam int NVEC = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_valid, tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic       rx_ready = 1'b0, rx_full = 1'b0;
    logic [3:0] rx_err = '0;
    logic [7:0] rx_data = '0;
    logic       rx_pop, rx_en, rx_flush, dbrk_clr, irq;
    logic       brk_evt = 1'b0, cos_flag = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    logic       cap_flush, cap_dclr;
    logic [7:0] rd_val;
    logic       rd_pop;

    always #2 clk = ~clk;

    uart_ctrl_regs #(.DIV_A(DIV_A), .DIV_B(DIV_B)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_ready(rx_ready), .rx_full(rx_full), .rx_err(rx_err),
        .rx_data(rx_data), .rx_pop(rx_pop), .rx_en(rx_en),
        .rx_flush(rx_flush), .brk_evt(brk_evt), .cos_flag(cos_flag),
        .dbrk_clr(dbrk_clr), .irq(irq)
    );

    // {req[3:0], wr, addr[5:0], wdata[7:0], expected read[7:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {4'd2,  1'b1, 6'h00, 8'h11, 8'h00},
        {4'd2,  1'b1, 6'h00, 8'h22, 8'h00},
        {4'd2,  1'b0, 6'h00, 8'h00, 8'h22},
        {4'd2,  1'b1, 6'h08, 8'h10, 8'h00},
        {4'd2,  1'b0, 6'h00, 8'h00, 8'h11},
        {4'd3,  1'b0, 6'h04, 8'h00, 8'h08},
        {4'd11, 1'b1, 6'h04, 8'hFF, 8'h00},
        {4'd11, 1'b0, 6'h04, 8'h00, 8'h08},
        {4'd4,  1'b1, 6'h08, 8'h04, 8'h00},
        {4'd3,  1'b0, 6'h04, 8'h00, 8'h0C},
        {4'd8,  1'b0, 6'h14, 8'h00, 8'h01},
        {4'd11, 1'b1, 6'h10, 8'h55, 8'h00},
        {4'd11, 1'b0, 6'h10, 8'h00, 8'h00},
        {4'd11, 1'b0, 6'h18, 8'h00, DIV_A},
        {4'd11, 1'b0, 6'h1C, 8'h00, DIV_B},
        {4'd11, 1'b0, 6'h08, 8'h00, 8'h00},
        {4'd11, 1'b0, 6'h3C, 8'h00, 8'h00},
        {4'd4,  1'b1, 6'h08, 8'h0C, 8'h00},
        {4'd4,  1'b0, 6'h04, 8'h00, 8'h0C},
        {4'd4,  1'b1, 6'h08, 8'h08, 8'h00},
        {4'd4,  1'b0, 6'h04, 8'h00, 8'h08}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        cap_flush = rx_flush;
        cap_dclr  = dbrk_clr;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic do_rd(input logic [5:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        rd_val = bus_rdata;
        rd_pop = rx_pop;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    initial begin
        #400000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
        chk("R1 rx_en", {7'b0, rx_en}, 8'h00);
        do_rd(6'h04); chk("R1 status", rd_val, 8'h08);
        do_rd(6'h14); chk("R1 isr", rd_val, 8'h00);
        do_rd(6'h00); chk("R1 mode", rd_val, 8'h00);

        // vector table: R2 R3 R4 R8 R11
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][22]) begin
                do_wr(VEC[i][21:16], VEC[i][15:8]);
            end else begin
                do_rd(VEC[i][21:16]);
                chk($sformatf("R%0d vec %0d", VEC[i][26:23], i), rd_val, VEC[i][7:0]);
            end
        end

        // R6 holding byte and handshake
        do_wr(6'h0C, 8'hA5);
        chk("R6 disabled no valid", {7'b0, tx_valid}, 8'h00);
        do_rd(6'h04); chk("R6 status pending", rd_val, 8'h00);
        do_wr(6'h08, 8'h04);
        chk("R6 valid after enable", {7'b0, tx_valid}, 8'h01);
        chk("R6 data", tx_data, 8'hA5);
        @(negedge clk); #1;
        chk("R6 valid held", {7'b0, tx_valid}, 8'h01);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0; #1;
        chk("R6 accepted", {7'b0, tx_valid}, 8'h00);
        do_rd(6'h04); chk("R6 status empty", rd_val, 8'h0C);
        // collision: accept old byte and write new one together
        do_wr(6'h0C, 8'h5A);
        @(negedge clk);
        tx_ready = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h0C; bus_wdata = 8'h77;
        @(negedge clk);
        tx_ready = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; #1;
        chk("R6 collide valid", {7'b0, tx_valid}, 8'h01);
        chk("R6 collide data", tx_data, 8'h77);
        do_rd(6'h04); chk("R6 collide status", rd_val, 8'h04);

        // R4 transmitter reset
        do_wr(6'h08, 8'h30);
        chk("R4 reset drops", {7'b0, tx_valid}, 8'h00);
        do_rd(6'h04); chk("R4 reset status", rd_val, 8'h08);
        do_wr(6'h08, 8'h34);
        do_rd(6'h04); chk("R4 reset+enable", rd_val, 8'h0C);
        chk("R4 reset+enable valid", {7'b0, tx_valid}, 8'h00);

        // R5 receiver commands
        do_wr(6'h08, 8'h01);
        chk("R5 enable", {7'b0, rx_en}, 8'h01);
        chk("R5 no flush", {7'b0, cap_flush}, 8'h00);
        do_wr(6'h08, 8'h03);
        chk("R5 reserved", {7'b0, rx_en}, 8'h01);
        do_wr(6'h08, 8'h20);
        chk("R5 flush pulse", {7'b0, cap_flush}, 8'h01);
        chk("R5 reset disables", {7'b0, rx_en}, 8'h00);
        chk("R5 flush ends", {7'b0, rx_flush}, 8'h00);
        do_wr(6'h08, 8'h21);
        chk("R5 flush+enable pulse", {7'b0, cap_flush}, 8'h01);
        chk("R5 flush+enable", {7'b0, rx_en}, 8'h01);
        do_wr(6'h08, 8'h02);
        chk("R5 disable", {7'b0, rx_en}, 8'h00);

        // R7 receive data reads
        rx_ready = 1'b1; rx_data = 8'h9E;
        do_rd(6'h0C);
        chk("R7 data", rd_val, 8'h9E);
        chk("R7 pop", {7'b0, rd_pop}, 8'h01);
        do_rd(6'h04);
        chk("R7 no pop other", {7'b0, rd_pop}, 8'h00);
        chk("R3 status rx ready", rd_val, 8'h0D);
        rx_ready = 1'b0;
        do_rd(6'h0C);
        chk("R7 empty data", rd_val, 8'h00);
        chk("R7 empty no pop", {7'b0, rd_pop}, 8'h00);

        // R3 full status layout
        rx_ready = 1'b1; rx_full = 1'b1; rx_err = 4'b1010;
        do_rd(6'h04); chk("R3 status all", rd_val, 8'hAF);
        rx_err = 4'b0000;

        // R8 interrupt sources
        do_rd(6'h14); chk("R8 ready source", rd_val, 8'h03);
        rx_full = 1'b0;
        do_rd(6'h14); chk("R8 ready source not full", rd_val, 8'h03);
        do_wr(6'h08, 8'h10);
        do_wr(6'h00, 8'h40);
        do_rd(6'h14); chk("R8 full source", rd_val, 8'h01);
        rx_full = 1'b1;
        do_rd(6'h14); chk("R8 full source set", rd_val, 8'h03);
        cos_flag = 1'b1;
        do_rd(6'h14); chk("R8 cos", rd_val, 8'h83);
        cos_flag = 1'b0;
        do_rd(6'h00); chk("R2 pointer advanced", rd_val, 8'h22);

        // R9 mask
        chk("R9 masked", {7'b0, irq}, 8'h00);
        do_wr(6'h14, 8'h02);
        chk("R9 rx irq", {7'b0, irq}, 8'h01);
        rx_full = 1'b0; #1;
        chk("R9 rx irq drops", {7'b0, irq}, 8'h00);
        do_wr(6'h14, 8'h80);
        cos_flag = 1'b1; #1;
        chk("R9 cos irq", {7'b0, irq}, 8'h01);
        cos_flag = 1'b0; #1;
        chk("R9 cos irq drops", {7'b0, irq}, 8'h00);
        do_wr(6'h14, 8'h00);
        rx_ready = 1'b0;

        // R10 break-change flag
        @(negedge clk) brk_evt = 1'b1;
        @(negedge clk) brk_evt = 1'b0;
        do_rd(6'h14); chk("R10 set", rd_val, 8'h05);
        do_wr(6'h08, 8'h50);
        chk("R10 clear pulse", {7'b0, cap_dclr}, 8'h01);
        do_rd(6'h14); chk("R10 cleared", rd_val, 8'h01);
        @(negedge clk);
        brk_evt = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 8'h50;
        #1; chk("R10 collide pulse", {7'b0, dbrk_clr}, 8'h01);
        @(negedge clk);
        brk_evt = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        do_rd(6'h14); chk("R10 event wins", rd_val, 8'h05);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule